// File: doc/BRIEF.md
# Parity-Protected SRAM Controller

The block sits in front of a word-organised on-chip SRAM. It keeps one even-parity bit per byte lane next to every stored word, and checks all lanes of a word whenever that word is read. A read that finds a bad lane raises a one-cycle error pulse next to the read data. The same read also records the byte offset of the failing word in a capture register, unless software has turned capture off. For fault-handling tests, a debug mode stores inverted parity for every lane written to one chosen word offset. The next reads of that word then fail on purpose.

A small hardware fill engine sets the whole array to zero with correct parity, one word per clock. While it runs, the memory port shows not-ready and ignores requests. The engine is a two-state machine. `FILL_IDLE` goes to `FILL_RUN` on the transition *start* (software writes 1 to the clear bit while idle). `FILL_RUN` loops on itself on *advance* (word pointer not yet at the last word). It returns to `FILL_IDLE` on *finish* (the last word is written).

Software controls the block through four 32-bit registers. The register index is taken from address bits 3:2.

| Offset | Name | Bits in use |
|---|---|---|
| 0x0 | CTL | bit 0 injection enable, bit 8 capture disable, both read/write |
| 0x4 | CAP | bits 23:0 captured offset, read-only |
| 0x8 | DBG | bits 23:0 injection word offset, read/write |
| 0xC | MEM | bit 0 clear start/status, bit 1 busy (read-only) |

Top module: `parsram_ctrl`

## Requirements
- R1: A memory write accepted with `m_req=1`, `m_we=1` and `m_ready=1` updates only the byte lanes whose `m_be` bit is set (bit i covers data bits 8i+7:8i). A read accepted at a clock edge returns the stored word on `m_rdata` with `m_rvalid=1` during the following cycle only.
- R2: Each lane's stored parity bit is the XOR of its eight data bits (even parity). `m_perr` is 1, together with `m_rvalid`, in the response cycle of a read whose word has any lane with a mismatching parity bit. It is 0 in every other cycle.
- R3: A parity-failing read, with CTL bit 8 clear at acceptance, loads CAP bits 23:0 with the word index times 4. The new value is visible in the same cycle as `m_perr`. CAP bits 31:24 read 0.
- R4: While CTL bit 8 is 1, failing reads still pulse `m_perr` but leave CAP unchanged.
- R5: While CTL bit 0 is 1, a write to the word whose index times 4 equals DBG bits 23:0 stores inverted parity for each lane it writes. Writes to any other word store correct parity.
- R6: A lane with inverted parity keeps failing reads until that lane is rewritten with injection off. A partial rewrite repairs only the lanes it writes.
- R7: DBG is read/write in bits 23:0, and bits 31:24 read 0 whatever is written.
- R8: Writing 1 to MEM bit 0 while idle sets MEM bit 1 (busy) from the next cycle for exactly WORDS cycles. Afterwards every word reads 0x00000000 with no parity error.
- R9: While busy, `m_ready` is 0. A request made then is not performed: it writes nothing and produces no `m_rvalid`.
- R10: MEM bit 0 reads 1 while the fill runs and clears by itself when the fill ends. Writing 1 to it while busy does not restart or lengthen the fill.
- R11: After reset all four registers read 0 and `m_rvalid` is 0. Only CTL bits 8 and 0 are writable, and all other CTL bits read 0.
- R12: Register-port writes to CAP have no effect. If such a write and a capture happen in the same cycle, the captured offset is kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| m_req | input | 1 | Memory request valid |
| m_we | input | 1 | 1 = write, 0 = read |
| m_addr | input | $clog2(WORDS) | Word index |
| m_be | input | DATA_W/8 | Byte-lane write enables |
| m_wdata | input | DATA_W | Write data |
| m_ready | output | 1 | Request accepted when 1; 0 while filling |
| m_rvalid | output | 1 | Read data valid, the cycle after acceptance |
| m_rdata | output | DATA_W | Read data |
| m_perr | output | 1 | Parity error pulse, aligned with m_rvalid |
| r_en | input | 1 | Register access valid |
| r_we | input | 1 | Register write strobe |
| r_addr | input | 4 | Register byte offset (bits 3:2 select) |
| r_wdata | input | 32 | Register write data |
| r_rdata | output | 32 | Register read data, combinational from r_addr |

## Verification
A memory write takes effect at the edge that accepts it. Read data, `m_perr` and the new CAP value all belong to the single cycle after the accepting edge. Register writes are visible in the cycle after their edge, and register reads are combinational. Busy rises in the cycle after the MEM write and lasts WORDS cycles. The bench drives every input on the falling edge and samples outputs at the next falling edge after the edge that matters, so each result is read exactly in its due cycle. A falling-edge counter measures the fill length directly.

// File: rtl/psc_pkg.sv
`timescale 1ns/1ps
package psc_pkg;
    localparam int OFS_W = 24;
    localparam int REG_W = 32;

    localparam logic [1:0] RI_CTL = 2'd0;
    localparam logic [1:0] RI_CAP = 2'd1;
    localparam logic [1:0] RI_DBG = 2'd2;
    localparam logic [1:0] RI_MEM = 2'd3;

    localparam int CTL_INJ_BIT    = 0;
    localparam int CTL_CAPOFF_BIT = 8;
    localparam int MEM_CLR_BIT    = 0;
    localparam int MEM_BUSY_BIT   = 1;

    typedef enum logic {
        FILL_IDLE = 1'b0,
        FILL_RUN  = 1'b1
    } fill_state_t;
endpackage

// File: rtl/psc_fill_fsm.sv
`timescale 1ns/1ps
module psc_fill_fsm
    import psc_pkg::*;
#(
    parameter int WORDS = 64,
    parameter int IDX_W = $clog2(WORDS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    output logic             busy,
    output logic             fill_we,
    output logic [IDX_W-1:0] fill_idx,
    output logic             fill_last
);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(WORDS - 1);

    fill_state_t      state_q, state_d;
    logic [IDX_W-1:0] idx_q;

    // next-state logic: start, advance, finish
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            FILL_IDLE: if (start) state_d = FILL_RUN;
            FILL_RUN:  if (idx_q == LAST_IDX) state_d = FILL_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= FILL_IDLE;
            idx_q   <= '0;
        end else begin
            state_q <= state_d;
            if (state_q == FILL_IDLE) idx_q <= '0;
            else                      idx_q <= idx_q + 1'b1;
        end
    end

    // outputs
    always_comb begin
        busy      = 1'b0;
        fill_we   = 1'b0;
        fill_last = 1'b0;
        fill_idx  = idx_q;
        unique case (state_q)
            FILL_IDLE: ;
            FILL_RUN: begin
                busy      = 1'b1;
                fill_we   = 1'b1;
                fill_last = (idx_q == LAST_IDX);
            end
        endcase
    end
endmodule

// File: rtl/psc_array.sv
`timescale 1ns/1ps
module psc_array #(
    parameter int WORDS  = 64,
    parameter int DATA_W = 32,
    parameter int IDX_W  = $clog2(WORDS),
    parameter int LANES  = DATA_W / 8
) (
    input  logic              clk,
    input  logic              we,
    input  logic [IDX_W-1:0]  widx,
    input  logic [LANES-1:0]  wbe,
    input  logic [DATA_W-1:0] wdata,
    input  logic              wflip,
    input  logic [IDX_W-1:0]  ridx,
    output logic [DATA_W-1:0] rdata,
    output logic              rbad
);
    logic [DATA_W-1:0] data_q [WORDS];
    logic [LANES-1:0]  par_q  [WORDS];
    logic [LANES-1:0]  rpar;
    logic [LANES-1:0]  lane_bad;

    always_ff @(posedge clk) begin
        if (we) begin
            for (int l = 0; l < LANES; l++) begin
                if (wbe[l]) begin
                    data_q[widx][8*l +: 8] <= wdata[8*l +: 8];
                    par_q[widx][l]         <= (^wdata[8*l +: 8]) ^ wflip;
                end
            end
        end
    end

    assign rdata = data_q[ridx];
    assign rpar  = par_q[ridx];

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign lane_bad[g] = (^rdata[8*g +: 8]) != rpar[g];
    end

    assign rbad = |lane_bad;
endmodule

// File: rtl/psc_regs.sv
`timescale 1ns/1ps
module psc_regs
    import psc_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             r_en,
    input  logic             r_we,
    input  logic [3:0]       r_addr,
    input  logic [REG_W-1:0] r_wdata,
    output logic [REG_W-1:0] r_rdata,
    input  logic             busy,
    input  logic             fill_last,
    input  logic             cap_ev,
    input  logic [OFS_W-1:0] cap_ofs,
    output logic             inj_on,
    output logic             cap_off,
    output logic [OFS_W-1:0] dbg_ofs,
    output logic [OFS_W-1:0] cap_q,
    output logic             start
);
    logic [1:0] sel;
    logic       wr;
    logic       clr_q;
    logic       unused_bits;

    assign sel         = r_addr[3:2];
    assign wr          = r_en && r_we;
    assign start       = wr && (sel == RI_MEM) && r_wdata[MEM_CLR_BIT] && !clr_q;
    assign unused_bits = ^{r_wdata[REG_W-1:OFS_W], r_addr[1:0]};

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            inj_on  <= 1'b0;
            cap_off <= 1'b0;
            dbg_ofs <= '0;
            cap_q   <= '0;
            clr_q   <= 1'b0;
        end else begin
            if (wr && sel == RI_CTL) begin
                inj_on  <= r_wdata[CTL_INJ_BIT];
                cap_off <= r_wdata[CTL_CAPOFF_BIT];
            end
            if (wr && sel == RI_DBG) dbg_ofs <= r_wdata[OFS_W-1:0];
            // hardware capture is the only writer of cap_q
            if (cap_ev && !cap_off) cap_q <= cap_ofs;
            if (start)          clr_q <= 1'b1;
            else if (fill_last) clr_q <= 1'b0;
        end
    end

    always_comb begin
        r_rdata = '0;
        unique case (sel)
            RI_CTL: begin
                r_rdata[CTL_INJ_BIT]    = inj_on;
                r_rdata[CTL_CAPOFF_BIT] = cap_off;
            end
            RI_CAP: r_rdata[OFS_W-1:0] = cap_q;
            RI_DBG: r_rdata[OFS_W-1:0] = dbg_ofs;
            RI_MEM: begin
                r_rdata[MEM_CLR_BIT]  = clr_q;
                r_rdata[MEM_BUSY_BIT] = busy;
            end
        endcase
    end
endmodule

// File: rtl/parsram_ctrl.sv
`timescale 1ns/1ps
module parsram_ctrl
    import psc_pkg::*;
#(
    parameter int WORDS  = 64,
    parameter int DATA_W = 32,
    localparam int IDX_W = $clog2(WORDS),
    localparam int LANES = DATA_W / 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              m_req,
    input  logic              m_we,
    input  logic [IDX_W-1:0]  m_addr,
    input  logic [LANES-1:0]  m_be,
    input  logic [DATA_W-1:0] m_wdata,
    output logic              m_ready,
    output logic              m_rvalid,
    output logic [DATA_W-1:0] m_rdata,
    output logic              m_perr,
    input  logic              r_en,
    input  logic              r_we,
    input  logic [3:0]        r_addr,
    input  logic [31:0]       r_wdata,
    output logic [31:0]       r_rdata
);
    logic              busy, fill_we, fill_last, start;
    logic [IDX_W-1:0]  fill_idx;
    logic              inj_on, cap_off;
    logic [OFS_W-1:0]  dbg_ofs, cap_q, acc_ofs;
    logic              acc, acc_rd, inj_hit;
    logic              arr_we, arr_flip, arr_bad;
    logic [IDX_W-1:0]  arr_idx;
    logic [LANES-1:0]  arr_be;
    logic [DATA_W-1:0] arr_wdata, arr_rdata;
    logic              rvalid_q, perr_q;
    logic [DATA_W-1:0] rdata_q;

    assign m_ready = !busy;
    assign acc     = m_req && m_ready;
    assign acc_rd  = acc && !m_we;
    assign acc_ofs = OFS_W'({m_addr, 2'b00});
    assign inj_hit = inj_on && (dbg_ofs == acc_ofs);

    // fill engine owns the write port while busy
    assign arr_we    = fill_we || (acc && m_we);
    assign arr_idx   = fill_we ? fill_idx : m_addr;
    assign arr_be    = fill_we ? '1 : m_be;
    assign arr_wdata = fill_we ? '0 : m_wdata;
    assign arr_flip  = !fill_we && inj_hit;

    psc_fill_fsm #(.WORDS(WORDS)) u_fill (
        .clk(clk), .rst_n(rst_n), .start(start), .busy(busy),
        .fill_we(fill_we), .fill_idx(fill_idx), .fill_last(fill_last)
    );

    psc_array #(.WORDS(WORDS), .DATA_W(DATA_W)) u_arr (
        .clk(clk), .we(arr_we), .widx(arr_idx), .wbe(arr_be),
        .wdata(arr_wdata), .wflip(arr_flip), .ridx(m_addr),
        .rdata(arr_rdata), .rbad(arr_bad)
    );

    psc_regs u_regs (
        .clk(clk), .rst_n(rst_n), .r_en(r_en), .r_we(r_we),
        .r_addr(r_addr), .r_wdata(r_wdata), .r_rdata(r_rdata),
        .busy(busy), .fill_last(fill_last),
        .cap_ev(acc_rd && arr_bad), .cap_ofs(acc_ofs),
        .inj_on(inj_on), .cap_off(cap_off), .dbg_ofs(dbg_ofs),
        .cap_q(cap_q), .start(start)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rvalid_q <= 1'b0;
            perr_q   <= 1'b0;
            rdata_q  <= '0;
        end else begin
            rvalid_q <= acc_rd;
            perr_q   <= acc_rd && arr_bad;
            if (acc_rd) rdata_q <= arr_rdata;
        end
    end

    assign m_rvalid = rvalid_q;
    assign m_perr   = perr_q;
    assign m_rdata  = rdata_q;
endmodule

// File: rtl/psc_checker.sv
`timescale 1ns/1ps
module psc_checker #(
    parameter int WORDS = 64,
    localparam int IDX_W = $clog2(WORDS),
    localparam int CW = $clog2(WORDS) + 2
) (
    input logic             clk,
    input logic             rst_n,
    input logic             m_req,
    input logic             m_we,
    input logic [IDX_W-1:0] m_addr,
    input logic             m_ready,
    input logic             m_rvalid,
    input logic             m_perr,
    input logic [3:0]       r_addr,
    input logic [31:0]      r_rdata,
    input logic             busy,
    input logic [23:0]      cap_q,
    input logic             cap_off
);
    logic [CW-1:0] busy_cnt;

    always_ff @(posedge clk) begin
        if (!rst_n)     busy_cnt <= '0;
        else if (busy)  busy_cnt <= busy_cnt + 1'b1;
        else            busy_cnt <= '0;
    end

    assert_rvalid_source_R1: assert property (@(posedge clk) disable iff (!rst_n)
        m_rvalid |-> $past(m_req && m_ready && !m_we));

    assert_perr_with_data_R2: assert property (@(posedge clk) disable iff (!rst_n)
        m_perr |-> m_rvalid);

    assert_capture_offset_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (m_perr && !$past(cap_off)) |-> (cap_q == 24'({$past(m_addr), 2'b00})));

    assert_capture_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !m_perr |-> $stable(cap_q));

    assert_fill_length_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> (busy_cnt == CW'(WORDS)));

    assert_no_rsp_blocked_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (m_req && !m_ready) |=> !m_rvalid);

    assert_ctl_reserved_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (r_addr[3:2] == 2'd0) |-> (r_rdata[31:9] == '0 && r_rdata[7:1] == '0));
endmodule

bind parsram_ctrl psc_checker #(.WORDS(WORDS)) u_chk (
    .clk(clk), .rst_n(rst_n), .m_req(m_req), .m_we(m_we), .m_addr(m_addr),
    .m_ready(m_ready), .m_rvalid(m_rvalid), .m_perr(m_perr),
    .r_addr(r_addr), .r_rdata(r_rdata), .busy(busy),
    .cap_q(cap_q), .cap_off(cap_off)
);

// File: tb/sim_parsram_ctrl.sv
`timescale 1ns/1ps
module sim_parsram_ctrl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        m_req = 1'b0, m_we = 1'b0;
    logic [5:0]  m_addr = '0;
    logic [3:0]  m_be = '0;
    logic [31:0] m_wdata = '0;
    logic        m_ready, m_rvalid, m_perr;
    logic [31:0] m_rdata;
    logic        r_en = 1'b0, r_we = 1'b0;
    logic [3:0]  r_addr = '0;
    logic [31:0] r_wdata = '0;
    logic [31:0] r_rdata;

    int total = 0;
    int bad = 0;
    int busy_cycles = 0;
    logic count_on = 1'b0;

    always #5 clk = ~clk;

    parsram_ctrl u0 (.*);

    always @(negedge clk) if (count_on && !m_ready) busy_cycles++;

    typedef struct packed {
        logic        we;
        logic [5:0]  addr;
        logic [3:0]  be;
        logic [31:0] data;
        logic        err;
    } vec_t;

    localparam int NV = 9;
    localparam vec_t VECS [NV] = '{
        '{1'b1, 6'd3,  4'hF, 32'hA5A5_1234, 1'b0},
        '{1'b0, 6'd3,  4'h0, 32'hA5A5_1234, 1'b0},
        '{1'b1, 6'd3,  4'h2, 32'h0000_FF00, 1'b0},
        '{1'b0, 6'd3,  4'h0, 32'hA5A5_FF34, 1'b0},
        '{1'b1, 6'd10, 4'h9, 32'h1122_3344, 1'b0},
        '{1'b0, 6'd10, 4'h0, 32'h1100_0044, 1'b0},
        '{1'b0, 6'd0,  4'h0, 32'h0000_0000, 1'b0},
        '{1'b1, 6'd63, 4'hF, 32'hFFFF_FFFF, 1'b0},
        '{1'b0, 6'd63, 4'h0, 32'hFFFF_FFFF, 1'b0}
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic reg_wr(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        r_en = 1'b1; r_we = 1'b1; r_addr = a; r_wdata = d;
        @(posedge clk); #1;
        r_en = 1'b0; r_we = 1'b0;
    endtask

    task automatic reg_rd(input logic [3:0] a, output logic [31:0] d);
        @(negedge clk);
        r_en = 1'b1; r_we = 1'b0; r_addr = a;
        #1 d = r_rdata;
        r_en = 1'b0;
    endtask

    task automatic mem_wr(input logic [5:0] a, input logic [3:0] be, input logic [31:0] d);
        @(negedge clk);
        m_req = 1'b1; m_we = 1'b1; m_addr = a; m_be = be; m_wdata = d;
        @(posedge clk); #1;
        m_req = 1'b0; m_we = 1'b0;
    endtask

    task automatic mem_rd(input logic [5:0] a, output logic [31:0] d, output logic e, output logic v);
        @(negedge clk);
        m_req = 1'b1; m_we = 1'b0; m_addr = a;
        @(posedge clk);
        @(negedge clk);
        m_req = 1'b0;
        d = m_rdata; e = m_perr; v = m_rvalid;
    endtask

    task automatic wait_idle();
        for (int i = 0; i < 500; i++) begin
            @(negedge clk);
            if (m_ready) break;
        end
    endtask

    task automatic summary();
        $display("  test done: total=%0d bad=%0d", total, bad);
    endtask

    initial begin
        #2_000_000;
        total++; bad++;
        $display("FAIL watchdog actual=hung expected=finished");
        summary();
        $finish;
    end

    initial begin
        logic [31:0] d;
        logic e, v;

        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // reset state
        reg_rd(4'h0, d); check("R11 CTL reset", d, 0);
        reg_rd(4'h4, d); check("R11 CAP reset", d, 0);
        reg_rd(4'h8, d); check("R11 DBG reset", d, 0);
        reg_rd(4'hC, d); check("R11 MEM reset", d, 0);
        check("R11 ready after reset", {31'd0, m_ready}, 1);
        check("R11 rvalid after reset", {31'd0, m_rvalid}, 0);

        // first clear so all parity is consistent; status while running
        reg_wr(4'hC, 32'h1);
        reg_rd(4'hC, d); check("R10 MEM busy+clr", d, 32'h3);
        mem_wr(6'd9, 4'hF, 32'h1234_5678);
        mem_rd(6'd9, d, e, v); check("R9 no rvalid while busy", {31'd0, v}, 0);
        wait_idle();
        reg_rd(4'hC, d); check("R10 clr self-clear", d, 0);
        mem_rd(6'd9, d, e, v); check("R9 blocked write not stored", d, 0);

        // vector table
        for (int i = 0; i < NV; i++) begin
            if (VECS[i].we) mem_wr(VECS[i].addr, VECS[i].be, VECS[i].data);
            else begin
                mem_rd(VECS[i].addr, d, e, v);
                check("R1 read data", d, VECS[i].data);
                check("R1 rvalid", {31'd0, v}, 1);
                check("R2 good parity", {31'd0, e}, {31'd0, VECS[i].err});
            end
        end

        // injection on word 5 (offset 0x14)
        reg_wr(4'h0, 32'h1);
        reg_wr(4'h8, 32'h14);
        mem_wr(6'd5, 4'hF, 32'hCAFE_F00D);
        mem_rd(6'd5, d, e, v);
        check("R1 data kept under injection", d, 32'hCAFE_F00D);
        check("R5 injected error", {31'd0, e}, 1);
        reg_rd(4'h4, d); check("R3 capture offset", d, 32'h14);
        check("R2 perr one cycle", {31'd0, m_perr}, 0);
        mem_wr(6'd6, 4'hF, 32'h0BAD_BEEF);
        mem_rd(6'd6, d, e, v); check("R5 other word clean", {31'd0, e}, 0);

        // capture disabled
        reg_wr(4'h0, 32'h101);
        reg_wr(4'h8, 32'h20);
        mem_wr(6'd8, 4'hF, 32'h5555_AAAA);
        reg_wr(4'h0, 32'h100);
        mem_rd(6'd8, d, e, v); check("R4 perr with capture off", {31'd0, e}, 1);
        reg_rd(4'h4, d); check("R4 capture held", d, 32'h14);
        reg_wr(4'h0, 32'h0);
        mem_rd(6'd8, d, e, v); check("R6 error persists", {31'd0, e}, 1);
        reg_rd(4'h4, d); check("R3 capture second offset", d, 32'h20);

        // same-cycle register write to CAP and capture
        @(negedge clk);
        m_req = 1'b1; m_we = 1'b0; m_addr = 6'd5;
        r_en = 1'b1; r_we = 1'b1; r_addr = 4'h4; r_wdata = 32'h00AB_CDEF;
        @(posedge clk); #1;
        m_req = 1'b0; r_en = 1'b0; r_we = 1'b0;
        reg_rd(4'h4, d); check("R12 capture wins", d, 32'h14);
        reg_wr(4'h4, 32'hFFFF_FFFF);
        reg_rd(4'h4, d); check("R12 CAP write ignored", d, 32'h14);

        // partial repair
        mem_wr(6'd5, 4'h1, 32'h0000_0077);
        mem_rd(6'd5, d, e, v);
        check("R6 partial repair still bad", {31'd0, e}, 1);
        check("R1 partial data", d, 32'hCAFE_F077);
        mem_wr(6'd5, 4'hF, 32'h0102_0304);
        mem_rd(6'd5, d, e, v); check("R6 full rewrite repairs", {31'd0, e}, 0);

        // reserved bits
        reg_wr(4'h0, 32'hFFFF_FFFF);
        reg_rd(4'h0, d); check("R11 CTL writable bits", d, 32'h101);
        reg_wr(4'h8, 32'hFFFF_FFFF);
        reg_rd(4'h8, d); check("R7 DBG width", d, 32'h00FF_FFFF);
        reg_wr(4'h0, 32'h0);

        // timed clear with re-start attempt while busy
        busy_cycles = 0;
        count_on = 1'b1;
        reg_wr(4'hC, 32'h1);
        reg_wr(4'hC, 32'h1);
        wait_idle();
        count_on = 1'b0;
        check("R8 busy length", busy_cycles, 64);
        check("R10 restart ignored", busy_cycles, 64);
        mem_rd(6'd8, d, e, v);
        check("R8 cleared data", d, 0);
        check("R8 cleared parity", {31'd0, e}, 0);
        mem_rd(6'd63, d, e, v); check("R8 last word cleared", d, 0);

        summary();
        $finish;
    end
endmodule